// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which clock drives a small processor subsystem. At reset the CPU runs from an on-chip high-speed oscillator. Software, through a byte-wide register bus, may start a main high-speed source (crystal or external input) or a low-speed subsystem source (crystal or external input) and then request a switch to it. It drives the enable and mode pins of the analog oscillator models. It reports which clock is selected on a small encoded output that a glitch-free clock multiplexer outside the block consumes.

A switch request is held pending until the requested source is known to be stable. For a main crystal, a stabilization counter counts main-clock ticks and must reach a software-programmed threshold. An external main clock needs no wait. The subsystem source always waits a fixed number of its own ticks, whether crystal or external. The oscillator mode register may be written once per reset. A source cannot be stopped while it is requested or in use.

Top module: `clksw_ctrl`

## Requirements
- R1: The mode register (address 0) takes only the first write after reset; later writes leave its value unchanged until the next reset. Layout: bit7 main external input, bit6 main source enable, bit5 sub external input, bit4 sub source enable, bits2:1 sub drive level, bit0 main high gain.
- R2: `main_ext_sel` is high when mode bits 7 and 6 are both 1. `sub_ext_sel` is high when mode bits 5 and 4 are both 1. `main_high_gain` follows mode bit0. `sub_drive` follows mode bits 2:1 (00 low power, 01 normal, 10 ultra-low power).
- R3: The stabilization counter (read at address 2) is zero while the main source is stopped. While the main source runs it increments once per cycle with `main_tick` high. It saturates at its all-ones value.
- R4: With a main crystal (mode bits 7:6 = 01), a pending main request becomes active in the cycle after the counter is greater than or equal to the threshold register. The threshold is at address 3 and resets to all ones.
- R5: With an external main clock (mode bits 7:6 = 11) and the main source running, a pending main request becomes active without any counter condition.
- R6: The select register (address 4) holds the main request in bit0 and the sub request in bit1. It reads the active main status in bit4 and the active sub status in bit5. A request with an unconfigured source (mode enable bit 0) stays pending.
- R7: A sub request becomes active only after the sub source has run for SUB_WAIT cycles of `sub_tick`, for both crystal and external sub modes.
- R8: The oscillator control register (address 1) has main stop in bit7 and sub stop in bit6; both reset to 1. `main_osc_en`/`sub_osc_en` are their inverses. A write setting a stop bit is ignored while that source is requested or active.
- R9: `cpu_src` is 0 for the on-chip clock, 1 for the main source and 2 for the sub source; an active sub selection has priority over main.
- R10: Reserved bits (mode bit3, control bits 5:0) and addresses 5 to 7 read as zero.
- R11: Clearing a request bit drops that source's active status one cycle after the request register updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high with bus_sel |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| main_tick | input | 1 | One pulse per main-source clock cycle, synchronized |
| sub_tick | input | 1 | One pulse per sub-source clock cycle, synchronized |
| main_osc_en | output | 1 | Main source enable |
| main_ext_sel | output | 1 | Main source uses external input |
| main_high_gain | output | 1 | Main crystal high-gain setting |
| sub_osc_en | output | 1 | Sub source enable |
| sub_ext_sel | output | 1 | Sub source uses external input |
| sub_drive | output | 2 | Sub crystal drive level |
| cpu_src | output | 2 | Selected CPU clock source code |

## Verification
The bench builds the block with an 8-bit stabilization counter and SUB_WAIT of 6. This lets the counter reach saturation at 255 in a few hundred cycles. It also lets the sub wait finish after a handful of ticks, so every pending-to-active transition and the saturation edge fall within a short run. The main tick arrives every second cycle, so the threshold crossing is reached through a sequence of sparse increments rather than a continuous count. A second reset exercises the external-clock modes, because the mode register cannot be rewritten.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int unsigned ADDR_MODE = 0;
    localparam int unsigned ADDR_OSC  = 1;
    localparam int unsigned ADDR_CNT  = 2;
    localparam int unsigned ADDR_THR  = 3;
    localparam int unsigned ADDR_SEL  = 4;

    localparam logic [7:0] MODE_MASK = 8'hF7;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2
    } cpu_src_e;

    typedef struct packed {
        logic       main_ext;
        logic       main_on;
        logic       sub_ext;
        logic       sub_on;
        logic       rsvd;
        logic [1:0] sub_drive;
        logic       main_gain;
    } mode_t;

endpackage

// File: rtl/clksw_stab_cnt.sv
module clksw_stab_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count == CMAX) |=> (count == CMAX));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(count));

endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
    import clksw_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              act_main,
    input  logic              act_sub,
    input  logic [CNT_W-1:0]  cnt_main,
    output logic [7:0]        rdata,
    output mode_t             mode,
    output logic              main_stop,
    output logic              sub_stop,
    output logic [CNT_W-1:0]  thr,
    output logic              req_main,
    output logic              req_sub
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_OSC  = ADDR_W'(ADDR_OSC);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_CNT);
    localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(ADDR_THR);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(ADDR_SEL);

    typedef struct packed {
        logic             locked;
        mode_t            mode;
        logic             main_stop;
        logic             sub_stop;
        logic [CNT_W-1:0] thr;
        logic             req_main;
        logic             req_sub;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    if (!q.locked) begin
                        d.mode   = mode_t'(wdata & MODE_MASK);
                        d.locked = 1'b1;
                    end
                end
                A_OSC: begin
                    // a stop request is refused while the source is wanted or in use
                    if (!(wdata[7] && (q.req_main || act_main))) d.main_stop = wdata[7];
                    if (!(wdata[6] && (q.req_sub  || act_sub)))  d.sub_stop  = wdata[6];
                end
                A_THR: d.thr = wdata[CNT_W-1:0];
                A_SEL: begin
                    d.req_main = wdata[0];
                    d.req_sub  = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.locked    <= 1'b0;
            q.mode      <= '0;
            q.main_stop <= 1'b1;
            q.sub_stop  <= 1'b1;
            q.thr       <= '1;
            q.req_main  <= 1'b0;
            q.req_sub   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = q.mode;
            A_OSC:   rdata = {q.main_stop, q.sub_stop, 6'b0};
            A_CNT:   rdata = 8'(cnt_main);
            A_THR:   rdata = 8'(q.thr);
            A_SEL:   rdata = {2'b0, act_sub, act_main, 2'b0, q.req_sub, q.req_main};
            default: rdata = 8'h00;
        endcase
    end

    assign mode      = q.mode;
    assign main_stop = q.main_stop;
    assign sub_stop  = q.sub_stop;
    assign thr       = q.thr;
    assign req_main  = q.req_main;
    assign req_sub   = q.req_sub;

    assert_mode_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MODE && q.locked) |=> $stable(q.mode));
    assert_main_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.main_stop && (q.req_main || act_main)) |=> !q.main_stop);
    assert_sub_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sub_stop && (q.req_sub || act_sub)) |=> !q.sub_stop);

endmodule

// File: rtl/clksw_select.sv
module clksw_select
    import clksw_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SUB_W    = 5,
    parameter int unsigned SUB_WAIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_ext,
    input  logic             main_on,
    input  logic             sub_on,
    input  logic             main_stop,
    input  logic             sub_stop,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] cnt_main,
    input  logic [SUB_W-1:0] cnt_sub,
    input  logic             req_main,
    input  logic             req_sub,
    output logic             act_main,
    output logic             act_sub,
    output cpu_src_e         cpu_src
);
    localparam logic [SUB_W-1:0] SUB_LIM = SUB_W'(SUB_WAIT);

    typedef struct packed {
        logic act_main;
        logic act_sub;
    } sel_t;

    sel_t d, q;
    logic main_ready, sub_ready;

    always_comb begin
        main_ready = main_on && !main_stop && (main_ext || (cnt_main >= thr));
        sub_ready  = sub_on && !sub_stop && (cnt_sub >= SUB_LIM);
        d.act_main = req_main && (q.act_main || main_ready);
        d.act_sub  = req_sub  && (q.act_sub  || sub_ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_main = q.act_main;
    assign act_sub  = q.act_sub;
    assign cpu_src  = q.act_sub ? SRC_SUB : (q.act_main ? SRC_MAIN : SRC_INT);

    assert_main_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_main) && !main_ext) |-> $past(cnt_main >= thr));
    assert_main_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_main) |-> ($past(req_main) && $past(!main_stop)));
    assert_sub_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_sub) |-> $past(cnt_sub >= SUB_LIM));
    assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_main && !req_sub) |=> (cpu_src == SRC_INT));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SUB_WAIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              main_tick,
    input  logic              sub_tick,
    output logic              main_osc_en,
    output logic              main_ext_sel,
    output logic              main_high_gain,
    output logic              sub_osc_en,
    output logic              sub_ext_sel,
    output logic [1:0]        sub_drive,
    output logic [1:0]        cpu_src
);
    localparam int unsigned SUB_W = $clog2(SUB_WAIT + 1);

    mode_t            mode;
    logic             main_stop, sub_stop, req_main, req_sub;
    logic             act_main, act_sub;
    logic [CNT_W-1:0] thr, cnt_main;
    logic [SUB_W-1:0] cnt_sub;
    cpu_src_e         src;

    clksw_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_sel && bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .act_main  (act_main),
        .act_sub   (act_sub),
        .cnt_main  (cnt_main),
        .rdata     (bus_rdata),
        .mode      (mode),
        .main_stop (main_stop),
        .sub_stop  (sub_stop),
        .thr       (thr),
        .req_main  (req_main),
        .req_sub   (req_sub)
    );

    clksw_stab_cnt #(.W(CNT_W)) u_main_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (main_stop),
        .tick  (main_tick),
        .count (cnt_main)
    );

    clksw_stab_cnt #(.W(SUB_W)) u_sub_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sub_stop),
        .tick  (sub_tick),
        .count (cnt_sub)
    );

    clksw_select #(.CNT_W(CNT_W), .SUB_W(SUB_W), .SUB_WAIT(SUB_WAIT)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_ext  (mode.main_ext),
        .main_on   (mode.main_on),
        .sub_on    (mode.sub_on),
        .main_stop (main_stop),
        .sub_stop  (sub_stop),
        .thr       (thr),
        .cnt_main  (cnt_main),
        .cnt_sub   (cnt_sub),
        .req_main  (req_main),
        .req_sub   (req_sub),
        .act_main  (act_main),
        .act_sub   (act_sub),
        .cpu_src   (src)
    );

    logic unused_rsvd;
    assign unused_rsvd    = mode.rsvd;

    assign cpu_src        = src;
    assign main_osc_en    = !main_stop;
    assign sub_osc_en     = !sub_stop;
    assign main_ext_sel   = mode.main_ext && mode.main_on;
    assign sub_ext_sel    = mode.sub_ext && mode.sub_on;
    assign main_high_gain = mode.main_gain;
    assign sub_drive      = mode.sub_drive;

    assert_main_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_main |-> main_osc_en);
    assert_sub_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_sub |-> sub_osc_en);
    assert_src_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src == 2'd1) |-> (act_main && !act_sub));

endmodule

// File: tb/tb_clksw_ctrl.sv
module tb_clksw_ctrl;
    localparam int ADDR_W   = 3;
    localparam int CNT_W    = 8;
    localparam int SUB_WAIT = 6;
    localparam int CMAX     = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              main_tick = 1'b0, sub_tick = 1'b0;
    logic              main_osc_en, main_ext_sel, main_high_gain;
    logic              sub_osc_en, sub_ext_sel;
    logic [1:0]        sub_drive, cpu_src;

    logic gen_m = 1'b0, gen_s = 1'b0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    clksw_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SUB_WAIT(SUB_WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .main_tick(main_tick), .sub_tick(sub_tick),
        .main_osc_en(main_osc_en), .main_ext_sel(main_ext_sel),
        .main_high_gain(main_high_gain), .sub_osc_en(sub_osc_en),
        .sub_ext_sel(sub_ext_sel), .sub_drive(sub_drive), .cpu_src(cpu_src)
    );

    // behavioural reference state
    bit       r_lock = 0, r_mstop = 1, r_xstop = 1;
    bit       r_reqm = 0, r_reqs = 0, r_actm = 0, r_acts = 0;
    bit [7:0] r_mode = 0;
    int       r_thr = CMAX, r_cnt = 0, r_scnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_lock = 0; r_mode = 0; r_mstop = 1; r_xstop = 1; r_thr = CMAX;
            r_reqm = 0; r_reqs = 0; r_actm = 0; r_acts = 0; r_cnt = 0; r_scnt = 0;
        end else begin
            bit rdy_m, rdy_s, nm, ns;
            rdy_m = r_mode[6] && !r_mstop && (r_mode[7] || r_cnt >= r_thr);
            rdy_s = r_mode[4] && !r_xstop && r_scnt >= SUB_WAIT;
            nm = r_reqm && (r_actm || rdy_m);
            ns = r_reqs && (r_acts || rdy_s);
            if (r_mstop) r_cnt = 0;
            else if (main_tick && r_cnt < CMAX) r_cnt++;
            if (r_xstop) r_scnt = 0;
            else if (sub_tick && r_scnt < SUB_WAIT) r_scnt++;
            if (bus_sel && bus_wr) begin
                case (int'(bus_addr))
                    0: if (!r_lock) begin r_mode = bus_wdata & 8'hF7; r_lock = 1; end
                    1: begin
                        if (!(bus_wdata[7] && (r_reqm || r_actm))) r_mstop = bus_wdata[7];
                        if (!(bus_wdata[6] && (r_reqs || r_acts))) r_xstop = bus_wdata[6];
                    end
                    3: r_thr = bus_wdata;
                    4: begin r_reqm = bus_wdata[0]; r_reqs = bus_wdata[1]; end
                    default: ;
                endcase
            end
            r_actm = nm;
            r_acts = ns;
        end
    end

    function automatic logic [7:0] exp_rd(int a);
        case (a)
            0: return r_mode;
            1: return {r_mstop, r_xstop, 6'b0};
            2: return 8'(r_cnt);
            3: return 8'(r_thr);
            4: return {2'b0, r_acts, r_actm, 2'b0, r_reqs, r_reqm};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 cpu_src", cpu_src, r_acts ? 2 : (r_actm ? 1 : 0));
            check("R8 main_osc_en", main_osc_en, !r_mstop);
            check("R8 sub_osc_en", sub_osc_en, !r_xstop);
            check("R2 main_ext_sel", main_ext_sel, r_mode[7] && r_mode[6]);
            check("R2 sub_ext_sel", sub_ext_sel, r_mode[5] && r_mode[4]);
            check("R2 main_high_gain", main_high_gain, r_mode[0]);
            check("R2 sub_drive", sub_drive, r_mode[2:1]);
            check("R6 readback", bus_rdata, exp_rd(int'(bus_addr)));
        end
    end

    always @(negedge clk) begin
        #1;
        main_tick <= gen_m ? ~main_tick : 1'b0;
        sub_tick  <= gen_s;
    end

    task automatic wr(int a, logic [7:0] v);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = v;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(int a, logic [7:0] exp, string tag);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(a);
        #2;
        check(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0; gen_m = 0; gen_s = 0;
        cyc(3);
        #1 rst_n = 1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        cyc(3);
        #1 rst_n = 1;
        // reset state
        rd(0, 8'h00, "R1 mode reset");
        rd(1, 8'hC0, "R8 osc ctl reset");
        rd(2, 8'h00, "R3 count reset");
        rd(3, 8'hFF, "R4 threshold reset");
        rd(4, 8'h00, "R6 select reset");
        check("R9 cpu_src reset", cpu_src, 0);

        // request with no source configured stays pending
        wr(4, 8'h01);
        cyc(5);
        rd(4, 8'h01, "R6 pending unconfigured");

        // crystal main, high gain, sub crystal normal drive
        wr(0, 8'h53);
        rd(0, 8'h53, "R1 first write");
        wr(0, 8'hFF);
        rd(0, 8'h53, "R1 second write ignored");
        check("R2 high gain", main_high_gain, 1);
        check("R2 sub drive", sub_drive, 1);

        wr(3, 8'd10);
        wr(1, 8'h40);
        gen_m = 1;
        cyc(6);
        rd(4, 8'h01, "R4 waiting below threshold");
        cyc(40);
        rd(4, 8'h11, "R4 active after threshold");
        check("R9 main selected", cpu_src, 1);

        wr(1, 8'hC0);
        rd(1, 8'h40, "R8 stop refused while active");
        check("R8 main still enabled", main_osc_en, 1);

        cyc(600);
        rd(2, 8'hFF, "R3 saturation");

        // sub source
        wr(4, 8'h03);
        wr(1, 8'h00);
        cyc(10);
        rd(4, 8'h13, "R7 sub pending without ticks");
        gen_s = 1;
        cyc(20);
        rd(4, 8'h33, "R7 sub active after wait");
        check("R9 sub priority", cpu_src, 2);

        wr(1, 8'h40);
        rd(1, 8'h00, "R8 sub stop refused");

        wr(4, 8'h00);
        cyc(3);
        check("R11 fallback to internal", cpu_src, 0);
        rd(4, 8'h00, "R11 status cleared");

        wr(1, 8'hFF);
        rd(1, 8'hC0, "R10 control reserved bits");
        cyc(3);
        rd(2, 8'h00, "R3 cleared when stopped");
        check("R8 main disabled", main_osc_en, 0);
        rd(5, 8'h00, "R10 addr 5");
        rd(6, 8'h00, "R10 addr 6");
        rd(7, 8'h00, "R10 addr 7");

        // external sources after a fresh reset
        do_reset();
        wr(0, 8'hF8);
        rd(0, 8'hF0, "R10 mode reserved bit");
        check("R2 main external", main_ext_sel, 1);
        check("R2 sub external", sub_ext_sel, 1);
        wr(1, 8'h00);
        wr(4, 8'h03);
        cyc(5);
        rd(4, 8'h13, "R5 external main without count");
        check("R5 main selected", cpu_src, 1);
        gen_s = 1;
        cyc(20);
        rd(4, 8'h33, "R7 external sub after wait");
        check("R9 sub selected", cpu_src, 2);

        cyc(2);
        finish_run();
    end
endmodule